// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block is the in-order commit end of an out-of-order core. The front end places decoded instructions into a circular queue in program order. Each slot keeps the destination register, a flag saying whether a destination exists, a result word and a done flag. Execution units deliver results in any order. Each result carries the slot index that the queue returned when the instruction was accepted.

The commit logic looks only at the oldest slot. In one clock it moves that slot's result, and the results of up to two following slots, into a 32-entry architectural register file. It stops at the first slot whose result has not arrived. A committed slot is released in the same cycle, so it can be handed out again. The register file is written only at commit.

Two registers follow special rules. Register 0 always reads zero. The link register (register 1) has its two lowest bits tied to zero. A read port lets the rest of the core see committed state.

Top module: `rob_commit`

## Requirements
- R1: After reset the queue is empty (`rob_empty`=1), `alloc_ready`=1, `retire_count`=0 and every architectural register reads 0.
- R2: Accepted instructions receive slot indices in program order. The index starts at 0 after reset, rises by one per accepted instruction, and wraps from DEPTH-1 to 0.
- R3: A completion stores its data only into an allocated slot. A completion that names a free slot changes nothing: `rob_empty` and `retire_count` are unaffected.
- R4: A completed result is invisible on the read port until its slot commits. Results of younger slots wait behind an incomplete oldest slot.
- R5: Each cycle, the block commits the run of consecutive done slots that starts at the oldest one. The run is limited to three slots. `retire_count` shows how many slots commit at the next clock edge.
- R6: Committing a slot releases it in that same cycle. With DEPTH slots in use, `alloc_ready` is 0. Released slots are allocated again.
- R7: A commit to register 1 writes the result with bits [1:0] cleared. Every other bit is written unchanged. Other registers keep all bits.
- R8: Register 0 reads 0 whatever is committed to it. A slot accepted with `alloc_has_dst`=0 commits without writing any register, even when `alloc_dst` is set.
- R9: When several slots that commit in the same cycle name the same register, the youngest slot's value remains in that register.
- R10: Allocation and commit in the same cycle both take effect. Occupancy changes by (accepted − committed), so no slot is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | New instruction offered in program order |
| alloc_has_dst | input | 1 | Instruction writes a register |
| alloc_dst | input | 5 | Destination register number |
| alloc_ready | output | 1 | A free slot is available |
| alloc_tag | output | 4 | Slot index given to the offered instruction |
| cmpl_valid | input | 1 | Result delivery from an execution unit |
| cmpl_tag | input | 4 | Slot index the result belongs to |
| cmpl_data | input | 32 | Result value |
| retire_count | output | 2 | Number of slots committing at the next edge |
| rob_empty | output | 1 | No slot in use |
| rd_addr | input | 5 | Architectural register read address |
| rd_data | output | 32 | Committed value of that register |

## Verification
The bench builds the block with its defaults: 16 slots, 32 registers of 32 bits, a commit width of three, and a two-bit cleared field on register 1. With only 16 slots, a fill until `alloc_ready` drops takes a handful of cycles. That fill also leaves the queue full enough to wrap the slot index. The same fill gives a 16-slot burst that drains at three slots per cycle and exposes the run-limit edge. It lets one allocation land in a cycle that also commits, so the occupancy arithmetic can be checked through the total number of commits.

// File: rtl/rob_commit.sv
module rob_commit #(
  parameter int DEPTH      = 16,
  parameter int XLEN       = 32,
  parameter int NREG       = 32,
  parameter int RET_W      = 3,
  parameter int LINK_REG   = 1,
  parameter int LINK_ZBITS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        alloc_valid,
  input  logic                        alloc_has_dst,
  input  logic [$clog2(NREG)-1:0]     alloc_dst,
  output logic                        alloc_ready,
  output logic [$clog2(DEPTH)-1:0]    alloc_tag,
  input  logic                        cmpl_valid,
  input  logic [$clog2(DEPTH)-1:0]    cmpl_tag,
  input  logic [XLEN-1:0]             cmpl_data,
  output logic [$clog2(RET_W+1)-1:0]  retire_count,
  output logic                        rob_empty,
  input  logic [$clog2(NREG)-1:0]     rd_addr,
  output logic [XLEN-1:0]             rd_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int RW = $clog2(NREG);
  localparam int NW = $clog2(RET_W + 1);
  localparam logic [XLEN-1:0] LMASK = {{(XLEN-LINK_ZBITS){1'b1}}, {LINK_ZBITS{1'b0}}};

  logic [DEPTH-1:0] valid, done, hasd;
  logic [RW-1:0]    dst  [DEPTH];
  logic [XLEN-1:0]  data [DEPTH];
  logic [XLEN-1:0]  rf   [NREG];
  logic [AW-1:0]    head, tail;
  logic [CW-1:0]    count;
  logic [AW-1:0]    ridx [RET_W];
  logic [RET_W-1:0] ret;
  logic [NW-1:0]    nret;
  logic             alloc_fire;

  assign rob_empty    = (count == '0);
  assign alloc_ready  = (count != CW'(DEPTH));
  assign alloc_tag    = tail;
  assign alloc_fire   = alloc_valid && alloc_ready;
  assign retire_count = nret;
  assign rd_data      = (rd_addr == '0) ? '0 : rf[rd_addr];

  always_comb begin
    logic go;
    go   = !rob_empty;
    nret = '0;
    for (int k = 0; k < RET_W; k++) begin
      ridx[k] = head + AW'(k);
      go      = go && valid[ridx[k]] && done[ridx[k]];
      ret[k]  = go;
      nret    = nret + NW'(go);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0;
      done  <= '0;
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (cmpl_valid && valid[cmpl_tag]) done[cmpl_tag] <= 1'b1;
      for (int k = 0; k < RET_W; k++)
        if (ret[k]) valid[ridx[k]] <= 1'b0;
      if (alloc_fire) begin
        valid[tail] <= 1'b1;
        done[tail]  <= 1'b0;
        tail        <= tail + 1'b1;
      end
      head  <= head + AW'(nret);
      count <= count + CW'(alloc_fire) - CW'(nret);
    end
  end

  always_ff @(posedge clk) begin
    if (cmpl_valid && valid[cmpl_tag]) data[cmpl_tag] <= cmpl_data;
    if (alloc_fire) begin
      hasd[tail] <= alloc_has_dst;
      dst[tail]  <= alloc_dst;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) rf[r] <= '0;
    end else begin
      for (int k = 0; k < RET_W; k++)
        if (ret[k] && hasd[ridx[k]] && dst[ridx[k]] != '0)
          rf[dst[ridx[k]]] <= (dst[ridx[k]] == RW'(LINK_REG)) ? (data[ridx[k]] & LMASK)
                                                              : data[ridx[k]];
    end
  end

  assert_alloc_free_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> !valid[tail]);
  assert_slot_freed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nret != '0) |=> !valid[$past(head)]);
  assert_link_low_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf[LINK_REG][LINK_ZBITS-1:0] == '0);
  assert_r0_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rf[0] == '0);
  assert_count_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) == (valid == '0));
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: tb/rob_commit_test.sv
module rob_commit_test;
  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, alloc_has_dst = 0;
  logic [4:0] alloc_dst = 0;
  logic alloc_ready;
  logic [3:0] alloc_tag;
  logic cmpl_valid = 0;
  logic [3:0] cmpl_tag = 0;
  logic [31:0] cmpl_data = 0;
  logic [1:0] retire_count;
  logic rob_empty;
  logic [4:0] rd_addr = 0;
  logic [31:0] rd_data;
  int checks = 0, errors = 0, nxt = 0;

  always #10 clk = ~clk;

  rob_commit uut (.clk, .rst_n, .alloc_valid, .alloc_has_dst, .alloc_dst, .alloc_ready,
    .alloc_tag, .cmpl_valid, .cmpl_tag, .cmpl_data, .retire_count, .rob_empty,
    .rd_addr, .rd_data);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic alloc(input logic hd, input logic [4:0] d, output logic [3:0] tag);
    alloc_valid = 1; alloc_has_dst = hd; alloc_dst = d;
    tag = alloc_tag;
    check("R2 tag order", 32'(tag), 32'(nxt % 16));
    nxt++;
    @(negedge clk);
    alloc_valid = 0;
  endtask

  task automatic complete(input logic [3:0] tag, input logic [31:0] v);
    cmpl_valid = 1; cmpl_tag = tag; cmpl_data = v;
    @(negedge clk);
    cmpl_valid = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 empty", 32'(rob_empty), 1);
    check("R1 ready", 32'(alloc_ready), 1);
    check("R1 retire", 32'(retire_count), 0);
    rd(5'd5, v); check("R1 reg5", v, 0);
  endtask

  task automatic t_inorder;
    logic [3:0] t0, t1, t2, t3;
    logic [31:0] v;
    alloc(1, 3, t0); alloc(1, 4, t1); alloc(1, 5, t2); alloc(1, 6, t3);
    complete(t1, 32'h44); complete(t2, 32'h55); complete(t3, 32'h66);
    check("R4 blocked head", 32'(retire_count), 0);
    rd(5'd4, v); check("R4 reg4 not yet", v, 0);
    complete(t0, 32'h33);
    check("R5 three wide", 32'(retire_count), 3);
    @(negedge clk);
    check("R5 remainder", 32'(retire_count), 1);
    rd(5'd3, v); check("R5 reg3", v, 32'h33);
    rd(5'd5, v); check("R5 reg5", v, 32'h55);
    rd(5'd6, v); check("R5 reg6 not yet", v, 0);
    @(negedge clk);
    rd(5'd6, v); check("R5 reg6", v, 32'h66);
    check("R6 drained", 32'(rob_empty), 1);
  endtask

  task automatic t_link;
    logic [3:0] a, b;
    logic [31:0] v;
    alloc(1, 1, a); alloc(1, 2, b);
    complete(b, 32'h1234_5673); complete(a, 32'hFFFF_FFFF);
    @(negedge clk);
    rd(5'd1, v); check("R7 link masked", v, 32'hFFFF_FFFC);
    rd(5'd2, v); check("R7 other full", v, 32'h1234_5673);
  endtask

  task automatic t_zero;
    logic [3:0] a, b;
    logic [31:0] v;
    alloc(1, 0, a); alloc(0, 7, b);
    complete(a, 32'h5); complete(b, 32'h9);
    @(negedge clk);
    rd(5'd0, v); check("R8 reg0", v, 0);
    rd(5'd7, v); check("R8 no dst", v, 0);
    check("R8 retired", 32'(rob_empty), 1);
  endtask

  task automatic t_youngest;
    logic [3:0] a, b, c;
    logic [31:0] v;
    alloc(1, 8, a); alloc(1, 8, b); alloc(1, 8, c);
    complete(b, 22); complete(c, 33); complete(a, 11);
    check("R9 all three", 32'(retire_count), 3);
    @(negedge clk);
    rd(5'd8, v); check("R9 youngest", v, 33);
  endtask

  task automatic t_ignored;
    logic [3:0] a;
    logic [31:0] v;
    cmpl_valid = 1; cmpl_tag = 4'(nxt % 16); cmpl_data = 32'hDEAD;
    @(negedge clk);
    cmpl_valid = 0;
    check("R3 still empty", 32'(rob_empty), 1);
    check("R3 no retire", 32'(retire_count), 0);
    alloc(1, 9, a);
    check("R3 not done", 32'(retire_count), 0);
    complete(a, 77);
    @(negedge clk);
    rd(5'd9, v); check("R3 real data", v, 77);
  endtask

  task automatic t_full;
    logic [3:0] tg [16];
    logic [3:0] nt;
    logic [31:0] v;
    int sum;
    bit sent;
    for (int i = 0; i < 16; i++) alloc(1, 10, tg[i]);
    check("R6 full ready low", 32'(alloc_ready), 0);
    check("R6 full nonempty", 32'(rob_empty), 0);
    for (int i = 1; i < 16; i++) complete(tg[i], 100 + i);
    complete(tg[0], 100);
    check("R5 burst", 32'(retire_count), 3);
    check("R6 still full", 32'(alloc_ready), 0);
    sum = 3;
    @(negedge clk);
    check("R6 ready after free", 32'(alloc_ready), 1);
    sum += retire_count;
    alloc(1, 11, nt);
    check("R6 reused slot", 32'(nt), 32'(tg[0]));
    sent = 0;
    for (int c = 0; c < 40; c++) begin
      sum += retire_count;
      if (!rob_empty && retire_count == 0 && !sent) begin
        cmpl_valid = 1; cmpl_tag = nt; cmpl_data = 200; sent = 1;
      end
      @(negedge clk);
      cmpl_valid = 0;
      if (rob_empty) break;
    end
    check("R10 total commits", 32'(sum), 17);
    check("R10 empty", 32'(rob_empty), 1);
    rd(5'd10, v); check("R10 reg10", v, 115);
    rd(5'd11, v); check("R10 reg11", v, 200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_inorder;
    t_link;
    t_zero;
    t_youngest;
    t_ignored;
    t_full;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule